// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block performs interrupt entry once the gate descriptor for a vector is at hand. A one-cycle start strobe captures the vector, the gate (target code selector, 32-bit handler offset, gate kind) and the processor context: the operating mode, the current privilege level, the flags word, the code selector, the instruction pointer, the stack selector, the stack pointer and the three inner stack slots of the task-state table. The block then runs a fixed sequence of requests through three request/acknowledge ports: a vector-table read port, a stack-write port and a segment-load port.

In real mode the block first reads a 4-byte far pointer from the vector table. It then treats the entry as a 16-bit interrupt gate and pushes a 16-bit frame. In protected mode, a gate whose selector names a more privileged level than the current one causes a switch to the inner stack taken from the task-state slot of that level. The old stack selector and pointer are pushed onto the new stack before the usual frame. The push width follows the gate size. At the end the block loads the new code selector, computes the new instruction pointer and the interrupt-enable flag, and pulses done. A fault reported on any push or segment load ends the sequence at once with a fault pulse.

Top module: `igd_top`

## Requirements
- R1: In real mode the block issues one table read at `tbl_base + 4*vector`. Bits 31:16 of the returned word become the target code selector and bits 15:0 the handler offset. The gate inputs are ignored.
- R2: In real mode every push is 16 bits wide (`push_wide`=0), the interrupt flag is cleared and no stack switch is made, whatever `gate_kind` and `cpl` hold.
- R3: In protected mode with `cpl` numerically greater than the target selector's RPL (bits 1:0 of the selector), the block first requests a stack-segment load (`ld_is_ss`=1) of slot RPL of `inner_ss` (slot n in bits 16n+15:16n). It then pushes onto the slot-RPL pointer of `inner_sp` (slot n in bits 32n+31:32n): first the old stack selector, then the old stack pointer.
- R4: After any stack switch, the frame is pushed as flags, then old code selector, then old instruction pointer. When `cpl` is not greater than RPL, no stack-segment load is requested and only these three pushes occur. Push and segment-load requests never overlap.
- R5: The push width is 32 bits only in protected mode with `gate_kind[0]`=1 (a 32-bit gate); otherwise it is 16 bits. The width is chosen anew for each entry. A 16-bit push carries zeros in `push_data[31:16]`.
- R6: Each push is issued at the running stack pointer minus 2 (16-bit) or 4 (32-bit). Consecutive pushes step down by that amount. `new_sp` reports the final pointer and `new_ss` the stack selector in use.
- R7: For an interrupt gate (`gate_kind[1]`=0) `if_out` becomes 0. For a trap gate (`gate_kind[1]`=1) `if_out` takes bit 9 of the flags input.
- R8: The block requests a code-segment load (`ld_is_ss`=0) of the target selector. With a 32-bit gate `new_ip` is the full offset. With a 16-bit gate only `new_ip[15:0]` is replaced by the offset, and bits 31:16 keep the old instruction pointer.
- R9: A push or segment load acknowledged with its fault flag aborts the entry. The block pulses `fault`, issues no further request and returns to idle, and `new_cs`, `new_ip`, `new_ss`, `new_sp` and `if_out` keep their previous values.
- R10: A start strobe while `busy` is high is ignored.
- R11: Success pulses `done` for one cycle with `busy` already low. `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an entry (taken when idle) |
| vector | input | 8 | Vector number |
| gate_sel | input | 16 | Target code selector from the gate |
| gate_off | input | 32 | Handler offset from the gate |
| gate_kind | input | 2 | Bit 0: 32-bit gate; bit 1: trap gate |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| cpl | input | 2 | Current privilege level |
| flags_in | input | 32 | Current flags word (bit 9 = interrupt enable) |
| cs_in | input | 16 | Current code selector |
| ip_in | input | 32 | Current instruction pointer |
| ss_in | input | 16 | Current stack selector |
| sp_in | input | 32 | Current stack pointer |
| inner_ss | input | 48 | Task-state stack selectors for levels 0..2 |
| inner_sp | input | 96 | Task-state stack pointers for levels 0..2 |
| tbl_base | input | 32 | Real-mode vector table base |
| tbl_req | output | 1 | Table read request |
| tbl_addr | output | 32 | Table read address |
| tbl_valid | input | 1 | Table read data valid |
| tbl_data | input | 32 | Table read data |
| push_req | output | 1 | Stack write request |
| push_addr | output | 32 | Stack write address (already decremented) |
| push_data | output | 32 | Stack write data |
| push_wide | output | 1 | 1 = 32-bit write, 0 = 16-bit write |
| push_ack | input | 1 | Stack write acknowledge |
| push_fault | input | 1 | Stack write faulted (with ack) |
| ld_req | output | 1 | Segment load request |
| ld_is_ss | output | 1 | 1 = stack segment, 0 = code segment |
| ld_sel | output | 16 | Selector to load |
| ld_ack | input | 1 | Segment load acknowledge |
| ld_fault | input | 1 | Segment load faulted (with ack) |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle abort pulse |
| new_cs | output | 16 | New code selector |
| new_ip | output | 32 | New instruction pointer |
| new_ss | output | 16 | Stack selector after entry |
| new_sp | output | 32 | Stack pointer after entry |
| if_out | output | 1 | Interrupt-enable flag after entry |

## Verification
The hardest case to reach is an abort in the middle of the frame. The stack pointer has already moved, but the output context must stay as it was. The bench injects a fault on a chosen push index from its stack-port responder and then compares the outputs with those left by the previous successful entry. The inner-stack path is reached only with a selector RPL below `cpl` in protected mode. The bench uses two different target levels with distinct slot contents, so that a wrong slot index shows up in the segment-load selector and in the first push address. A 16-bit entry run directly after a 32-bit one shows whether the width carries over between entries.

// File: rtl/igd_pkg.sv
package igd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VEC  = 3'd1,
    ST_LDSS = 3'd2,
    ST_PUSH = 3'd3,
    ST_LDCS = 3'd4
  } igd_state_e;

  typedef enum logic [2:0] {
    FR_OLD_SS = 3'd0,
    FR_OLD_SP = 3'd1,
    FR_FLAGS  = 3'd2,
    FR_CS     = 3'd3,
    FR_IP     = 3'd4
  } igd_slot_e;

  localparam int IF_BIT = 9;
endpackage

// File: rtl/igd_frame_mux.sv
module igd_frame_mux #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  igd_pkg::igd_slot_e slot,
  input  logic               wide,
  input  logic [SW-1:0]      old_ss,
  input  logic [DW-1:0]      old_sp,
  input  logic [DW-1:0]      flags,
  input  logic [SW-1:0]      cs,
  input  logic [DW-1:0]      ip,
  output logic [DW-1:0]      data
);
  import igd_pkg::*;
  localparam int NW = 16;
  logic [DW-1:0] raw;

  always_comb begin
    case (slot)
      FR_OLD_SS: raw = {{(DW-SW){1'b0}}, old_ss};
      FR_OLD_SP: raw = old_sp;
      FR_FLAGS:  raw = flags;
      FR_CS:     raw = {{(DW-SW){1'b0}}, cs};
      default:   raw = ip;
    endcase
    data = wide ? raw : {{(DW-NW){1'b0}}, raw[NW-1:0]};
  end
endmodule

// File: rtl/igd_sp_step.sv
module igd_sp_step #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] sp,
  input  logic          wide,
  output logic [DW-1:0] sp_next
);
  localparam logic [DW-1:0] STEP_W = DW'(4);
  localparam logic [DW-1:0] STEP_N = DW'(2);
  assign sp_next = sp - (wide ? STEP_W : STEP_N);
endmodule

// File: rtl/igd_top.sv
module igd_top #(
  parameter int DW     = 32,
  parameter int SW     = 16,
  parameter int VW     = 8,
  parameter int LEVELS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [VW-1:0]        vector,
  input  logic [SW-1:0]        gate_sel,
  input  logic [DW-1:0]        gate_off,
  input  logic [1:0]           gate_kind,
  input  logic                 prot_mode,
  input  logic [1:0]           cpl,
  input  logic [DW-1:0]        flags_in,
  input  logic [SW-1:0]        cs_in,
  input  logic [DW-1:0]        ip_in,
  input  logic [SW-1:0]        ss_in,
  input  logic [DW-1:0]        sp_in,
  input  logic [LEVELS*SW-1:0] inner_ss,
  input  logic [LEVELS*DW-1:0] inner_sp,
  input  logic [DW-1:0]        tbl_base,
  output logic                 tbl_req,
  output logic [DW-1:0]        tbl_addr,
  input  logic                 tbl_valid,
  input  logic [DW-1:0]        tbl_data,
  output logic                 push_req,
  output logic [DW-1:0]        push_addr,
  output logic [DW-1:0]        push_data,
  output logic                 push_wide,
  input  logic                 push_ack,
  input  logic                 push_fault,
  output logic                 ld_req,
  output logic                 ld_is_ss,
  output logic [SW-1:0]        ld_sel,
  input  logic                 ld_ack,
  input  logic                 ld_fault,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [SW-1:0]        new_cs,
  output logic [DW-1:0]        new_ip,
  output logic [SW-1:0]        new_ss,
  output logic [DW-1:0]        new_sp,
  output logic                 if_out
);
  import igd_pkg::*;
  localparam int HW = DW / 2;

  igd_state_e state;
  igd_slot_e  slot;
  logic          wide_r, trap_r, g32_r;
  logic [SW-1:0] sel_r, cs_r, old_ss_r, stk_ss_r;
  logic [DW-1:0] off_r, flags_r, ip_r, old_sp_r, sp_r, addr_r, sp_next;

  logic [SW-1:0] lvl_ss [LEVELS];
  logic [DW-1:0] lvl_sp [LEVELS];
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign lvl_ss[g] = inner_ss[g*SW +: SW];
      assign lvl_sp[g] = inner_sp[g*DW +: DW];
    end
  endgenerate

  logic [1:0] tgt_rpl;
  logic       need_switch;
  assign tgt_rpl     = gate_sel[1:0];
  assign need_switch = (cpl > tgt_rpl) && (int'(tgt_rpl) < LEVELS);

  igd_sp_step #(.DW(DW)) u_step (.sp(sp_r), .wide(wide_r), .sp_next(sp_next));

  igd_frame_mux #(.DW(DW), .SW(SW)) u_mux (
    .slot(slot), .wide(wide_r), .old_ss(old_ss_r), .old_sp(old_sp_r),
    .flags(flags_r), .cs(cs_r), .ip(ip_r), .data(push_data)
  );

  assign busy      = (state != ST_IDLE);
  assign tbl_req   = (state == ST_VEC);
  assign tbl_addr  = addr_r;
  assign push_req  = (state == ST_PUSH);
  assign push_addr = sp_next;
  assign push_wide = wide_r;
  assign ld_req    = (state == ST_LDSS) || (state == ST_LDCS);
  assign ld_is_ss  = (state == ST_LDSS);
  assign ld_sel    = (state == ST_LDSS) ? stk_ss_r : sel_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot     <= FR_FLAGS;
      wide_r   <= 1'b0;
      trap_r   <= 1'b0;
      g32_r    <= 1'b0;
      sel_r    <= '0;
      cs_r     <= '0;
      old_ss_r <= '0;
      stk_ss_r <= '0;
      off_r    <= '0;
      flags_r  <= '0;
      ip_r     <= '0;
      old_sp_r <= '0;
      sp_r     <= '0;
      addr_r   <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
      new_cs   <= '0;
      new_ip   <= '0;
      new_ss   <= '0;
      new_sp   <= '0;
      if_out   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          flags_r  <= flags_in;
          cs_r     <= cs_in;
          ip_r     <= ip_in;
          old_ss_r <= ss_in;
          old_sp_r <= sp_in;
          stk_ss_r <= ss_in;
          sp_r     <= sp_in;
          addr_r   <= tbl_base + (DW'(vector) << 2);
          sel_r    <= gate_sel;
          off_r    <= gate_off;
          slot     <= FR_FLAGS;
          if (!prot_mode) begin
            wide_r <= 1'b0;
            g32_r  <= 1'b0;
            trap_r <= 1'b0;
            state  <= ST_VEC;
          end else begin
            wide_r <= gate_kind[0];
            g32_r  <= gate_kind[0];
            trap_r <= gate_kind[1];
            if (need_switch) begin
              stk_ss_r <= lvl_ss[tgt_rpl];
              sp_r     <= lvl_sp[tgt_rpl];
              slot     <= FR_OLD_SS;
              state    <= ST_LDSS;
            end else begin
              state <= ST_PUSH;
            end
          end
        end
        ST_VEC: if (tbl_valid) begin
          sel_r <= tbl_data[DW-1:HW];
          off_r <= {{HW{1'b0}}, tbl_data[HW-1:0]};
          state <= ST_PUSH;
        end
        ST_LDSS: if (ld_ack) begin
          if (ld_fault) begin
            fault <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_PUSH;
          end
        end
        ST_PUSH: if (push_ack) begin
          if (push_fault) begin
            fault <= 1'b1;
            state <= ST_IDLE;
          end else begin
            sp_r <= sp_next;
            if (slot == FR_IP) state <= ST_LDCS;
            else slot <= igd_slot_e'(slot + 3'd1);
          end
        end
        ST_LDCS: if (ld_ack) begin
          state <= ST_IDLE;
          if (ld_fault) begin
            fault <= 1'b1;
          end else begin
            done   <= 1'b1;
            new_cs <= sel_r;
            new_ip <= g32_r ? off_r : {ip_r[DW-1:HW], off_r[HW-1:0]};
            new_ss <= stk_ss_r;
            new_sp <= sp_r;
            if_out <= trap_r ? flags_r[IF_BIT] : 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/igd_checker.sv
module igd_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          prot_mode,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          push_req,
  input logic [DW-1:0] push_addr,
  input logic [DW-1:0] push_data,
  input logic          push_wide,
  input logic          push_ack,
  input logic          push_fault,
  input logic          ld_req
);
  logic real_q;
  always_ff @(posedge clk) begin
    if (rst) real_q <= 1'b0;
    else if (start && !busy) real_q <= !prot_mode;
  end

  assert_done_fault_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_idle_at_end_R11: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> !busy);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(push_req && ld_req));

  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (push_req && !push_wide) |-> (push_data[DW-1:16] == '0));

  assert_real_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    (real_q && push_req) |-> !push_wide);

  assert_push_step_R6: assert property (@(posedge clk) disable iff (rst)
    (push_req && push_ack && !push_fault) ##1 push_req |->
      (push_addr == $past(push_addr) - (push_wide ? DW'(4) : DW'(2))));

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (fault && !start) |=> (!push_req && !ld_req));
endmodule

bind igd_top igd_checker #(.DW(DW)) u_igd_checker (
  .clk(clk), .rst(rst), .start(start), .prot_mode(prot_mode), .busy(busy),
  .done(done), .fault(fault), .push_req(push_req), .push_addr(push_addr),
  .push_data(push_data), .push_wide(push_wide), .push_ack(push_ack),
  .push_fault(push_fault), .ld_req(ld_req)
);

// File: tb/test_igd_top.sv
module test_igd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [15:0] gate_sel = '0;
  logic [31:0] gate_off = '0;
  logic [1:0]  gate_kind = '0;
  logic        prot_mode = 1'b0;
  logic [1:0]  cpl = '0;
  logic [31:0] flags_in = '0;
  logic [15:0] cs_in = '0;
  logic [31:0] ip_in = '0;
  logic [15:0] ss_in = '0;
  logic [31:0] sp_in = '0;
  logic [47:0] inner_ss = {16'h0022, 16'h0021, 16'h0010};
  logic [95:0] inner_sp = {32'h0000_6000, 32'h0000_5000, 32'h0000_9000};
  logic [31:0] tbl_base = 32'h0000_1000;
  logic        tbl_req, tbl_valid = 1'b0;
  logic [31:0] tbl_addr, tbl_data = '0;
  logic        push_req, push_wide, push_ack = 1'b0, push_fault = 1'b0;
  logic [31:0] push_addr, push_data;
  logic        ld_req, ld_is_ss, ld_ack = 1'b0, ld_fault = 1'b0;
  logic [15:0] ld_sel;
  logic        busy, done, fault, if_out;
  logic [15:0] new_cs, new_ss;
  logic [31:0] new_ip, new_sp;

  igd_top i_igd_top (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int push_n = 0, ld_n = 0, tbl_n = 0, done_n = 0, fault_n = 0;
  int fault_push_idx = -1;
  bit fault_ld_cs = 1'b0;
  logic [31:0] pa_log [16];
  logic [31:0] pd_log [16];
  logic        pw_log [16];
  logic [15:0] ls_log [4];
  logic        lk_log [4];
  logic [31:0] ta_log;

  always @(negedge clk) begin
    push_ack   <= push_req;
    push_fault <= push_req && (push_n == fault_push_idx);
    ld_ack     <= ld_req;
    ld_fault   <= ld_req && !ld_is_ss && fault_ld_cs;
    tbl_valid  <= tbl_req;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (push_req && push_ack) begin
      if (push_n < 16) begin
        pa_log[push_n] = push_addr;
        pd_log[push_n] = push_data;
        pw_log[push_n] = push_wide;
      end
      push_n = push_n + 1;
    end
    if (ld_req && ld_ack) begin
      if (ld_n < 4) begin
        ls_log[ld_n] = ld_sel;
        lk_log[ld_n] = ld_is_ss;
      end
      ld_n = ld_n + 1;
    end
    if (tbl_req && tbl_valid) begin
      ta_log = tbl_addr;
      tbl_n = tbl_n + 1;
    end
    if (done) done_n = done_n + 1;
    if (fault) fault_n = fault_n + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    push_n = 0; ld_n = 0; tbl_n = 0; done_n = 0; fault_n = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_n + fault_n > 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset busy", 32'(busy), 0);
    check("R11 reset done", 32'(done), 0);
    check("R9 reset fault", 32'(fault), 0);
    check("R4 reset push_req", 32'(push_req), 0);
  endtask

  task automatic t_real();
    clear_logs();
    prot_mode = 0; cpl = 2'd3; vector = 8'h21; gate_kind = 2'b01;
    gate_sel = 16'h0003; gate_off = 32'hFFFF_FFFF;
    tbl_data = 32'hABCD_1234; flags_in = 32'h0000_0202; cs_in = 16'h0700;
    ip_in = 32'h1234_5678; ss_in = 16'h0030; sp_in = 32'h0000_0100;
    pulse_start(); wait_end();
    check("R1 table addr", ta_log, 32'h0000_1084);
    check("R1 table reads", tbl_n, 1);
    check("R2 push count", push_n, 3);
    check("R2 push width", {29'b0, pw_log[0], pw_log[1], pw_log[2]}, 0);
    check("R6 push0 addr", pa_log[0], 32'h0000_00FE);
    check("R4 push0 flags", pd_log[0], 32'h0000_0202);
    check("R6 push1 addr", pa_log[1], 32'h0000_00FC);
    check("R4 push1 cs", pd_log[1], 32'h0000_0700);
    check("R4 push2 ip", pd_log[2], 32'h0000_5678);
    check("R2 ld count", ld_n, 1);
    check("R8 ld cs sel", {15'b0, lk_log[0], ls_log[0]}, 32'h0000_ABCD);
    check("R1 new_cs", 32'(new_cs), 32'h0000_ABCD);
    check("R8 new_ip", new_ip, 32'h1234_1234);
    check("R2 if_out", 32'(if_out), 0);
    check("R6 new_sp", new_sp, 32'h0000_00FA);
    check("R6 new_ss", 32'(new_ss), 32'h0000_0030);
    check("R11 done", done_n, 1);
  endtask

  task automatic t_prot_switch();
    clear_logs();
    prot_mode = 1; cpl = 2'd3; gate_sel = 16'h0008; gate_kind = 2'b01;
    gate_off = 32'hC0DE_1234; flags_in = 32'h0000_0246; cs_in = 16'h001B;
    ip_in = 32'h0040_1000; ss_in = 16'h002B; sp_in = 32'h0000_7000;
    pulse_start(); wait_end();
    check("R3 first ld is ss", 32'(lk_log[0]), 1);
    check("R3 ss sel", 32'(ls_log[0]), 32'h0000_0010);
    check("R3 push count", push_n, 5);
    check("R3 push0 addr", pa_log[0], 32'h0000_8FFC);
    check("R3 push0 old ss", pd_log[0], 32'h0000_002B);
    check("R3 push1 old sp", pd_log[1], 32'h0000_7000);
    check("R4 push2 flags", pd_log[2], 32'h0000_0246);
    check("R4 push3 cs", pd_log[3], 32'h0000_001B);
    check("R4 push4 ip", pd_log[4], 32'h0040_1000);
    check("R5 wide", 32'(pw_log[4]), 1);
    check("R6 push4 addr", pa_log[4], 32'h0000_8FEC);
    check("R8 new_ip 32", new_ip, 32'hC0DE_1234);
    check("R7 int gate if", 32'(if_out), 0);
    check("R6 new_ss", 32'(new_ss), 32'h0000_0010);
    check("R6 new_sp", new_sp, 32'h0000_8FEC);
  endtask

  task automatic t_prot_trap16();
    clear_logs();
    prot_mode = 1; cpl = 2'd0; gate_sel = 16'h0010; gate_kind = 2'b10;
    gate_off = 32'h0000_BEEF; flags_in = 32'h0000_0202; cs_in = 16'h0013;
    ip_in = 32'hAAAA_5555; ss_in = 16'h0018; sp_in = 32'h0000_2000;
    pulse_start(); wait_end();
    check("R4 no ss load", ld_n, 1);
    check("R4 push count", push_n, 3);
    check("R5 narrow after wide", 32'(pw_log[0]), 0);
    check("R6 push0 addr", pa_log[0], 32'h0000_1FFE);
    check("R4 push2 ip", pd_log[2], 32'h0000_5555);
    check("R6 push2 addr", pa_log[2], 32'h0000_1FFA);
    check("R8 new_ip 16", new_ip, 32'hAAAA_BEEF);
    check("R7 trap keeps if", 32'(if_out), 1);
  endtask

  task automatic t_rpl1();
    clear_logs();
    prot_mode = 1; cpl = 2'd2; gate_sel = 16'h0009; gate_kind = 2'b00;
    gate_off = 32'h0000_0100; ss_in = 16'h002B; sp_in = 32'h0001_7000;
    pulse_start(); wait_end();
    check("R3 slot1 sel", 32'(ls_log[0]), 32'h0000_0021);
    check("R3 slot1 addr", pa_log[0], 32'h0000_4FFE);
    check("R3 slot1 old sp", pd_log[1], 32'h0000_7000);
    check("R7 int16 if", 32'(if_out), 0);
    check("R8 cs", 32'(new_cs), 32'h0000_0009);
  endtask

  task automatic t_fault_push();
    logic [31:0] ip0;
    ip0 = new_ip;
    clear_logs();
    prot_mode = 1; cpl = 2'd0; gate_sel = 16'h0010; gate_kind = 2'b10;
    gate_off = 32'h0000_BEEF; flags_in = 32'h0000_0202; ss_in = 16'h0018;
    sp_in = 32'h0000_2000; fault_push_idx = 1;
    pulse_start(); wait_end();
    fault_push_idx = -1;
    check("R9 fault pulse", fault_n, 1);
    check("R9 no done", done_n, 0);
    check("R9 pushes stop", push_n, 2);
    check("R9 no ld", ld_n, 0);
    check("R9 cs kept", 32'(new_cs), 32'h0000_0009);
    check("R9 ip kept", new_ip, ip0);
    check("R9 idle", 32'(busy), 0);
  endtask

  task automatic t_fault_ld();
    clear_logs();
    fault_ld_cs = 1;
    pulse_start(); wait_end();
    fault_ld_cs = 0;
    check("R9 ld fault", fault_n, 1);
    check("R9 ld no done", done_n, 0);
    check("R9 ld pushes", push_n, 3);
    check("R9 ld cs kept", 32'(new_cs), 32'h0000_0009);
  endtask

  task automatic t_busy_start();
    clear_logs();
    prot_mode = 0; vector = 8'h21; tbl_data = 32'hABCD_1234; sp_in = 32'h0000_0100;
    pulse_start();
    vector = 8'h05;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_end();
    check("R10 one table read", tbl_n, 1);
    check("R10 table addr", ta_log, 32'h0000_1084);
    check("R10 pushes", push_n, 3);
    check("R10 one done", done_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_real();
    t_prot_switch();
    t_prot_trap16();
    t_rpl1();
    t_fault_push();
    t_fault_ld();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule